// File: doc/BRIEF.md
# Exponential Backoff Sequencer

When several requesters contend for the same memory word, a requester whose compare-and-swap keeps losing needs to wait a little longer before each retry, so the others can finish. This sequencer produces that waiting time. It keeps a backoff count for the current atomic sequence. Every failed attempt turns the count into a stall length in cycles and hands that length to an external pause timer as one request. When the timer reports completion, the sequencer signals that the requester may retry and doubles the count for the next failure.

A requester pulses `seq_start_i` when it begins a new atomic operation, pulses `cas_fail_i` after each lost attempt, and pulses `cas_ok_i` when the operation finally succeeds. The pause timer takes `stall_len_o` when `stall_go_o` is high and answers with `stall_done_i`. The stall is issued in one piece: each count unit stands for 128 cycles, and the full product goes out in a single request. The count grows by doubling and stops growing once it has passed a ceiling of 4096, so it settles at 8192.

Top module: `backoff_seq`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `stall_go_o` and `retry_ok_o` are 0 and `stall_len_o` is 0.
- R2: A start pulse sets the count to 1, so the first failure after a start requests a stall of 128 cycles (`stall_len_o` = count × 128, i.e. the count shifted left by 7).
- R3: A failure pulse while the sequencer waits for an attempt result raises `stall_go_o` for exactly one cycle, in the cycle after the pulse; `stall_len_o` carries the requested length from that cycle on and keeps it until the next request.
- R4: Each time the pause timer reports completion, the count doubles, so consecutive stalls of one sequence are 128, 256, 512, ... cycles.
- R5: Doubling is skipped when the count is already above 4096; the count therefore saturates at 8192 and every later stall is 1048576 cycles.
- R6: A failure pulse that arrives while a stall is outstanding is ignored: no new request is issued.
- R7: `stall_done_i` during an outstanding stall raises `retry_ok_o` for exactly one cycle, in the cycle after it; `stall_done_i` at any other time has no effect.
- R8: A success pulse returns the sequencer to idle from any state; in idle, failure and completion pulses are ignored until the next start.
- R9: A start pulse takes effect in every state, including during a stall, and has priority over success and failure in the same cycle; the next failure again requests 128 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| seq_start_i | input | 1 | Pulse: a new atomic sequence begins |
| cas_fail_i | input | 1 | Pulse: the last compare-and-swap attempt failed |
| cas_ok_i | input | 1 | Pulse: the atomic operation succeeded |
| stall_done_i | input | 1 | Pulse from the pause timer: the requested stall has elapsed |
| stall_go_o | output | 1 | One-cycle strobe: start a stall of `stall_len_o` cycles |
| stall_len_o | output | 21 | Requested stall length in cycles (count × 128) |
| retry_ok_o | output | 1 | One-cycle pulse: the requester may retry now |

## Verification
On every cycle the bound checker confirms that the request strobe and the retry pulse each last one cycle, that no second request appears while a stall is outstanding, that a retry pulse only follows a completion report, and that each requested length is a power of two no larger than the saturated value, equal to 128 for the first request of a sequence and to double the previous one (or the same once past the ceiling) afterwards. Only the bench scenarios show the full length series across seventeen failures, that failures during a stall and completions outside one leave the outputs untouched, and how start and success behave when they land in the middle of a stall or in idle.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  typedef enum logic [1:0] {
    BO_IDLE  = 2'd0,
    BO_ARMED = 2'd1,
    BO_STALL = 2'd2
  } bo_state_e;

endpackage

// File: rtl/backoff_fsm.sv
module backoff_fsm
  import backoff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seq_start_i,
  input  logic cas_fail_i,
  input  logic cas_ok_i,
  input  logic stall_done_i,
  output logic load_o,
  output logic issue_o,
  output logic finish_o,
  output logic stall_go_o,
  output logic retry_ok_o
);

  bo_state_e state_q, state_d;
  logic      go_q, ok_q;

  // next-state and control decode; start outranks success, success outranks the rest
  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    issue_o  = 1'b0;
    finish_o = 1'b0;
    if (seq_start_i) begin
      load_o  = 1'b1;
      state_d = BO_ARMED;
    end else if (cas_ok_i) begin
      state_d = BO_IDLE;
    end else begin
      unique case (state_q)
        BO_ARMED: begin
          if (cas_fail_i) begin
            issue_o = 1'b1;
            state_d = BO_STALL;
          end
        end
        BO_STALL: begin
          if (stall_done_i) begin
            finish_o = 1'b1;
            state_d  = BO_ARMED;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BO_IDLE;
      go_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= issue_o;
      ok_q    <= finish_o;
    end
  end

  assign stall_go_o = go_q;
  assign retry_ok_o = ok_q;

endmodule

// File: rtl/backoff_count.sv
module backoff_count #(
  parameter int unsigned CEIL  = 4096,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dbl_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CEIL_V = CNT_W'(CEIL);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  logic             past_ceil;

  assign past_ceil = (count_q > CEIL_V);
  assign count_en  = load_i | (dbl_i & ~past_ceil);

  always_comb begin
    if (load_i) count_d = CNT_W'(1);
    else        count_d = count_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= CNT_W'(1);
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/backoff_scale.sv
module backoff_scale #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned SHIFT   = 7,
  parameter int unsigned PAUSE_W = CNT_W + SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [PAUSE_W-1:0] len_o
);

  logic [PAUSE_W-1:0] len_q, len_d;

  assign len_d = PAUSE_W'(count_i) << SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (issue_i) len_q <= len_d;
  end

  assign len_o = len_q;

endmodule

// File: rtl/backoff_seq.sv
module backoff_seq #(
  parameter int unsigned CEIL      = 4096,
  parameter int unsigned SHIFT     = 7,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned CNT_W    = $clog2(CEIL) + 2,
  localparam int unsigned PAUSE_W  = CNT_W + SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_start_i,
  input  logic               cas_fail_i,
  input  logic               cas_ok_i,
  input  logic               stall_done_i,
  output logic               stall_go_o,
  output logic [PAUSE_W-1:0] stall_len_o,
  output logic               retry_ok_o
);

  logic [SYNC_DEPTH-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic                  load, issue, finish;
  logic [CNT_W-1:0]      count;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_DEPTH-1];

  backoff_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .seq_start_i  (seq_start_i),
    .cas_fail_i   (cas_fail_i),
    .cas_ok_i     (cas_ok_i),
    .stall_done_i (stall_done_i),
    .load_o       (load),
    .issue_o      (issue),
    .finish_o     (finish),
    .stall_go_o   (stall_go_o),
    .retry_ok_o   (retry_ok_o)
  );

  backoff_count #(.CEIL(CEIL), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (load),
    .dbl_i   (finish),
    .count_o (count)
  );

  backoff_scale #(.CNT_W(CNT_W), .SHIFT(SHIFT), .PAUSE_W(PAUSE_W)) u_scale (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .issue_i (issue),
    .count_i (count),
    .len_o   (stall_len_o)
  );

endmodule

// File: rtl/backoff_seq_chk.sv
module backoff_seq_chk #(
  parameter int unsigned CEIL    = 4096,
  parameter int unsigned SHIFT   = 7,
  parameter int unsigned PAUSE_W = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seq_start_i,
  input logic               cas_ok_i,
  input logic               stall_done_i,
  input logic               stall_go_o,
  input logic [PAUSE_W-1:0] stall_len_o,
  input logic               retry_ok_o
);

  localparam logic [PAUSE_W-1:0] FIRST_V = PAUSE_W'(1) << SHIFT;
  localparam logic [PAUSE_W-1:0] CEIL_V  = PAUSE_W'(CEIL) << SHIFT;
  localparam logic [PAUSE_W-1:0] MAX_V   = CEIL_V << 1;

  logic [PAUSE_W-1:0] last_q;
  logic               have_q;
  logic               busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (seq_start_i) begin
        have_q <= 1'b0;
      end else if (stall_go_o) begin
        have_q <= 1'b1;
        last_q <= stall_len_o;
      end
      if (seq_start_i || cas_ok_i || retry_ok_o) busy_q <= 1'b0;
      else if (stall_go_o)                      busy_q <= 1'b1;
    end
  end

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_go_o |=> !stall_go_o); // R3

  AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ok_o |=> !retry_ok_o); // R7

  AST_RETRY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_ok_o) |-> $past(stall_done_i)); // R7

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_go_o |-> !busy_q); // R6

  AST_LEN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_go_o |-> ($countones(stall_len_o) == 1 && stall_len_o >= FIRST_V
                    && stall_len_o <= MAX_V)); // R5

  AST_FIRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_go_o && !have_q) |-> (stall_len_o == FIRST_V)); // R2

  AST_DOUBLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_go_o && have_q) |->
      (stall_len_o == ((last_q > CEIL_V) ? last_q : (last_q << 1)))); // R4

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_go_o |-> $stable(stall_len_o)); // R3

endmodule

bind backoff_seq backoff_seq_chk #(
  .CEIL(CEIL), .SHIFT(SHIFT), .PAUSE_W(PAUSE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .seq_start_i  (seq_start_i),
  .cas_ok_i     (cas_ok_i),
  .stall_done_i (stall_done_i),
  .stall_go_o   (stall_go_o),
  .stall_len_o  (stall_len_o),
  .retry_ok_o   (retry_ok_o)
);

// File: tb/sim_backoff_seq.sv
`timescale 1ns/1ps
module sim_backoff_seq;

  logic        clk;
  logic        rst_n;
  logic        seq_start_i, cas_fail_i, cas_ok_i, stall_done_i;
  logic        stall_go_o, retry_ok_o;
  logic [20:0] stall_len_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  backoff_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_start_i  (seq_start_i),
    .cas_fail_i   (cas_fail_i),
    .cas_ok_i     (cas_ok_i),
    .stall_done_i (stall_done_i),
    .stall_go_o   (stall_go_o),
    .stall_len_o  (stall_len_o),
    .retry_ok_o   (retry_ok_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one-cycle pulses; returns at the negedge where registered results are visible
  task automatic pulse(input bit st, input bit fl, input bit ok, input bit dn);
    @(negedge clk);
    seq_start_i = st; cas_fail_i = fl; cas_ok_i = ok; stall_done_i = dn;
    @(negedge clk);
    seq_start_i = 0; cas_fail_i = 0; cas_ok_i = 0; stall_done_i = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    longint cnt;
    rst_n = 0; seq_start_i = 0; cas_fail_i = 0; cas_ok_i = 0; stall_done_i = 0;
    repeat (3) @(negedge clk);
    check(stall_go_o == 0 && retry_ok_o == 0, "R1 strobes in reset", stall_go_o + retry_ok_o, 0);
    check(stall_len_o == 0, "R1 length in reset", stall_len_o, 0);
    rst_n = 1;
    @(negedge clk);
    check(stall_go_o == 0 && retry_ok_o == 0 && stall_len_o == 0, "R1 after release",
          stall_len_o, 0);
    repeat (3) @(negedge clk);

    // failure before any start: idle ignores it
    pulse(0, 1, 0, 0);
    check(stall_go_o == 0, "R8 fail before start", stall_go_o, 0);

    pulse(1, 0, 0, 0);
    cnt = 1;
    for (int i = 0; i < 17; i++) begin
      pulse(0, 1, 0, 0);
      check(stall_go_o == 1, "R3 request strobe", stall_go_o, 1);
      if (i == 0) check(stall_len_o == 128, "R2 first length", stall_len_o, 128);
      else if (cnt == 8192) check(stall_len_o == cnt * 128, "R5 saturated length", stall_len_o, cnt * 128);
      else check(stall_len_o == cnt * 128, "R4 doubled length", stall_len_o, cnt * 128);
      @(negedge clk);
      check(stall_go_o == 0, "R3 strobe one cycle", stall_go_o, 0);
      check(stall_len_o == cnt * 128, "R3 length held", stall_len_o, cnt * 128);
      pulse(0, 1, 0, 0);
      check(stall_go_o == 0, "R6 fail during stall", stall_go_o, 0);
      check(retry_ok_o == 0, "R7 no retry before done", retry_ok_o, 0);
      pulse(0, 0, 0, 1);
      check(retry_ok_o == 1, "R7 retry after done", retry_ok_o, 1);
      @(negedge clk);
      check(retry_ok_o == 0, "R7 retry one cycle", retry_ok_o, 0);
      if (cnt <= 4096) cnt = cnt * 2;
    end

    // completion while no stall is outstanding
    pulse(0, 0, 0, 1);
    check(retry_ok_o == 0, "R7 done outside stall", retry_ok_o, 0);

    // success to idle, then fail and done ignored
    pulse(0, 0, 1, 0);
    pulse(0, 1, 0, 0);
    check(stall_go_o == 0, "R8 fail in idle", stall_go_o, 0);
    check(stall_len_o == 8192 * 128, "R8 length untouched in idle", stall_len_o, 8192 * 128);
    pulse(0, 0, 0, 1);
    check(retry_ok_o == 0, "R8 done in idle", retry_ok_o, 0);

    // restart reloads count
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    check(stall_go_o == 1 && stall_len_o == 128, "R9 restart length", stall_len_o, 128);
    pulse(0, 0, 0, 1);
    pulse(0, 1, 0, 0);
    check(stall_len_o == 256, "R4 second length", stall_len_o, 256);

    // start in the middle of a stall
    pulse(1, 0, 0, 0);
    pulse(0, 0, 0, 1);
    check(retry_ok_o == 0, "R9 start aborts stall", retry_ok_o, 0);
    pulse(0, 1, 0, 0);
    check(stall_go_o == 1 && stall_len_o == 128, "R9 start during stall", stall_len_o, 128);

    // start and success together: start wins
    pulse(1, 0, 1, 0);
    pulse(0, 1, 0, 0);
    check(stall_go_o == 1 && stall_len_o == 128, "R9 start beats success", stall_go_o, 1);

    // success during stall
    pulse(0, 0, 1, 0);
    pulse(0, 0, 0, 1);
    check(retry_ok_o == 0, "R8 success during stall", retry_ok_o, 0);
    pulse(0, 1, 0, 0);
    check(stall_go_o == 0, "R8 idle after success", stall_go_o, 0);

    finished = 1;
    summary();
  end

endmodule